// File: doc/BRIEF.md
# Clock Generator Watchdog with Safe-Frequency Fallback

This block supervises a clock generator. A prescaler divides the crystal clock into coarse time units of roughly 293 ms. Software programs a timeout as a whole number of these units and must service the watchdog before that many units have passed. If it does not, the block latches an alarm status and replaces the normal frequency-select code with a programmed safe code. It also pulses a system reset request for a fixed number of clock cycles.

The block holds the timeout register and the enable bit itself. Both are written through single-cycle strobes. Any write to either register, a service pulse, or a status clear restarts the count from zero. The safe code stays in force until software clears the status with a control write that has its clear bit set. While the status is set, the count is suspended, so one missed service produces exactly one reset pulse.

Top module: `clkgen_wdog`

## Requirements
- R1: After reset the timeout readback `tmo_q` is 16, `wd_en_q` is 0, `alarm_stat` is 0, `sys_rst_req` is 0, and `freq_sel` equals `norm_code`.
- R2: A cycle with `tmo_wr`=1 loads `tmo_val` into the timeout register, and `tmo_q` shows the new value from the next cycle.
- R3: While `wd_en_q` is 0, `alarm_stat` never rises and `sys_rst_req` stays 0.
- R4: With the watchdog enabled and timeout N≥1, `alarm_stat` rises exactly N×TICK_DIV clock cycles after the restart event, if no further restart occurs in between.
- R5: A timeout value of 0 expires on the first time unit, TICK_DIV cycles after the restart event.
- R6: Each of `kick`, `tmo_wr` and `ctl_wr` restarts the count from zero. A restart event in the cycle that carries the final time unit prevents expiry.
- R7: `freq_sel` equals `norm_code` while `alarm_stat` is 0 and equals `safe_code` while it is 1. The switch happens in the same cycle that `alarm_stat` rises.
- R8: `sys_rst_req` is high for exactly RST_LEN cycles, starting in the cycle in which `alarm_stat` rises.
- R9: `alarm_stat` stays set until a `ctl_wr` cycle with `ctl_clr`=1 clears it. A `ctl_wr` with `ctl_clr`=0 leaves it set. The clearing write also restarts the count.
- R10: While `alarm_stat` is set the count is suspended, so no further reset pulse occurs before the status is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_wr | input | 1 | Strobe: load the timeout register |
| tmo_val | input | 8 | Timeout in time units |
| ctl_wr | input | 1 | Strobe: load the enable bit, optionally clear the status |
| ctl_en | input | 1 | Enable value written by `ctl_wr` |
| ctl_clr | input | 1 | 1 with `ctl_wr` clears the alarm status |
| kick | input | 1 | Service pulse; restarts the count |
| safe_code | input | 5 | Fallback frequency-select code |
| norm_code | input | 5 | Normal frequency-select code |
| freq_sel | output | 5 | Effective frequency-select code |
| alarm_stat | output | 1 | Sticky alarm status |
| sys_rst_req | output | 1 | System reset request pulse |
| tmo_q | output | 8 | Timeout register readback |
| wd_en_q | output | 1 | Enable bit readback |

## Verification
The hardest case to reach is a restart that coincides with the final time unit. Only then is expiry suppressed rather than merely postponed. The stimulus reaches it by counting cycles from the last restart and timing a service pulse so that it is sampled on exactly the edge where the alarm would otherwise register. Random timeouts combined with random service positions then exercise the neighbouring offsets, including services one cycle early. Status suspension is checked by idling several timeout periods with the alarm set and confirming that no second reset pulse appears.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int TMO_W     = 8;
  localparam int CODE_W    = 5;
  localparam int TMO_RESET = 16;

  // True when the unit just completing is the last one of the window.
  // A limit of zero counts as expiring on the very first unit.
  function automatic logic unit_is_final(input logic [TMO_W-1:0] done,
                                         input logic [TMO_W-1:0] limit);
    logic [TMO_W:0] next_done;
    next_done = {1'b0, done} + {{TMO_W{1'b0}}, 1'b1};
    return next_done >= {1'b0, limit};
  endfunction

  function automatic logic [CODE_W-1:0] freq_pick(input logic alarm,
                                                  input logic [CODE_W-1:0] safe,
                                                  input logic [CODE_W-1:0] norm);
    return alarm ? safe : norm;
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int TICK_DIV = 4195174
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_cnt;

  assign tick = run && (pre_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_cnt <= '0;
    else if (restart || !run)    pre_cnt <= '0;
    else if (pre_cnt == LAST)    pre_cnt <= '0;
    else                         pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/wdg_unit_timer.sv
module wdg_unit_timer
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] units_done;
  logic             last_unit;

  assign last_unit = unit_is_final(units_done, limit);
  assign expire    = run && tick && last_unit && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             units_done <= '0;
    else if (restart)       units_done <= '0;
    else if (run && tick) begin
      if (last_unit)        units_done <= '0;
      else                  units_done <= units_done + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req
);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [RW-1:0] LOAD = RW'(RST_LEN);

  logic [RW-1:0] left;

  assign req = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (fire)        left <= LOAD;
    else if (left != '0)  left <= left - 1'b1;
  end
endmodule

// File: rtl/clkgen_wdog.sv
module clkgen_wdog
  import wdg_pkg::*;
#(
  parameter int TICK_DIV = 4195174,
  parameter int RST_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmo_wr,
  input  logic [TMO_W-1:0]  tmo_val,
  input  logic              ctl_wr,
  input  logic              ctl_en,
  input  logic              ctl_clr,
  input  logic              kick,
  input  logic [CODE_W-1:0] safe_code,
  input  logic [CODE_W-1:0] norm_code,
  output logic [CODE_W-1:0] freq_sel,
  output logic              alarm_stat,
  output logic              sys_rst_req,
  output logic [TMO_W-1:0]  tmo_q,
  output logic              wd_en_q
);
  // Named internal events, visible to the bound checker.
  logic restart_evt;
  logic clear_evt;
  logic run_en;
  logic unit_tick;
  logic expire_evt;

  assign restart_evt = tmo_wr || ctl_wr || kick;
  assign clear_evt   = ctl_wr && ctl_clr;
  assign run_en      = wd_en_q && !alarm_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_q <= TMO_W'(TMO_RESET);
    else if (tmo_wr) tmo_q <= tmo_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wd_en_q <= 1'b0;
    else if (ctl_wr) wd_en_q <= ctl_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alarm_stat <= 1'b0;
    else if (clear_evt)  alarm_stat <= 1'b0;
    else if (expire_evt) alarm_stat <= 1'b1;
  end

  wdg_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_en),
    .restart (restart_evt),
    .tick    (unit_tick)
  );

  wdg_unit_timer u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_en),
    .restart (restart_evt),
    .tick    (unit_tick),
    .limit   (tmo_q),
    .expire  (expire_evt)
  );

  wdg_rst_pulse #(.RST_LEN(RST_LEN)) u_rstp (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (expire_evt),
    .req   (sys_rst_req)
  );

  assign freq_sel = freq_pick(alarm_stat, safe_code, norm_code);
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart_evt,
  input logic              clear_evt,
  input logic              expire_evt,
  input logic              wd_en_q,
  input logic              alarm_stat,
  input logic              sys_rst_req,
  input logic [CODE_W-1:0] freq_sel,
  input logic [CODE_W-1:0] safe_code,
  input logic [CODE_W-1:0] norm_code
);
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_len <= '0;
    else if (sys_rst_req) hi_len <= hi_len + 1'b1;
    else                  hi_len <= '0;
  end

  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en_q |=> !$rose(alarm_stat));

  a_r4_expire_sets_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> alarm_stat);

  a_r6_restart_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> !$rose(alarm_stat));

  a_r7_safe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_stat) |-> (freq_sel == safe_code));

  a_r7_norm_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_stat) |-> (freq_sel == norm_code));

  a_r8_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_stat) |-> sys_rst_req);

  a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> (hi_len >= 16'(RST_LEN)));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_stat && !clear_evt) |=> alarm_stat);

  a_r10_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_stat |-> !expire_evt);
endmodule

bind clkgen_wdog wdg_checker #(.RST_LEN(RST_LEN)) u_wdg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart_evt (restart_evt),
  .clear_evt   (clear_evt),
  .expire_evt  (expire_evt),
  .wd_en_q     (wd_en_q),
  .alarm_stat  (alarm_stat),
  .sys_rst_req (sys_rst_req),
  .freq_sel    (freq_sel),
  .safe_code   (safe_code),
  .norm_code   (norm_code)
);

// File: tb/clkgen_wdog_bench.sv
module clkgen_wdog_bench;
  localparam int DIV = 6;
  localparam int LEN = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmo_wr = 1'b0, ctl_wr = 1'b0, ctl_en = 1'b0, ctl_clr = 1'b0, kick = 1'b0;
  logic [7:0] tmo_val = '0;
  logic [4:0] safe_code = 5'h15, norm_code = 5'h03;
  logic [4:0] freq_sel;
  logic       alarm_stat, sys_rst_req, wd_en_q;
  logic [7:0] tmo_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  clkgen_wdog #(.TICK_DIV(DIV), .RST_LEN(LEN)) u_clkgen_wdog (
    .clk(clk), .rst_n(rst_n), .tmo_wr(tmo_wr), .tmo_val(tmo_val),
    .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_clr(ctl_clr), .kick(kick),
    .safe_code(safe_code), .norm_code(norm_code), .freq_sel(freq_sel),
    .alarm_stat(alarm_stat), .sys_rst_req(sys_rst_req), .tmo_q(tmo_q),
    .wd_en_q(wd_en_q)
  );

  // Expected window length in cycles: a zero timeout acts as one unit.
  function automatic int window(input int n);
    return ((n == 0) ? 1 : n) * DIV;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_tmo(input int v);
    tmo_val = 8'(v); tmo_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    tmo_wr = 1'b0;
  endtask

  task automatic write_ctl(input bit en, input bit clr);
    ctl_en = en; ctl_clr = clr; ctl_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    ctl_wr = 1'b0; ctl_clr = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(posedge clk); @(negedge clk);
    kick = 1'b0;
  endtask

  // Called just after the restart edge; checks the expiry edge and the pulse.
  task automatic expect_expiry(input int t, input string req);
    int hi;
    wait_cyc(t - 1);
    chk({req, " alarm before window end"}, alarm_stat, 0);
    chk("R7 normal code before expiry", freq_sel, norm_code);
    wait_cyc(1);
    chk({req, " alarm at window end"}, alarm_stat, 1);
    chk("R7 safe code at expiry", freq_sel, safe_code);
    hi = 0;
    for (int i = 0; i < LEN + 2; i++) begin
      if (sys_rst_req) hi++;
      if (i == 0) chk("R8 pulse starts with alarm", sys_rst_req, 1);
      if (i == LEN) chk("R8 pulse ends after RST_LEN", sys_rst_req, 0);
      wait_cyc(1);
    end
    chk("R8 pulse length", hi, LEN);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int n, t, k, hi;
    void'($urandom(32'd20240611));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1
    chk("R1 timeout reset value", tmo_q, 16);
    chk("R1 enable reset value", wd_en_q, 0);
    chk("R1 alarm reset value", alarm_stat, 0);
    chk("R1 reset request idle", sys_rst_req, 0);
    chk("R1 normal code after reset", freq_sel, norm_code);

    // R3: disabled watchdog never fires
    hi = 0;
    for (int i = 0; i < 4 * window(16); i++) begin
      if (alarm_stat || sys_rst_req) hi++;
      wait_cyc(1);
    end
    chk("R3 no alarm while disabled", hi, 0);

    // R2
    write_tmo(3);
    chk("R2 timeout readback", tmo_q, 3);

    // R4 basic expiry, R10 suspension, R9 sticky/clear
    write_ctl(1'b1, 1'b0);
    expect_expiry(window(3), "R4");
    hi = 0;
    for (int i = 0; i < 3 * window(3); i++) begin
      if (sys_rst_req || !alarm_stat) hi++;
      wait_cyc(1);
    end
    chk("R10 no second pulse while alarm set", hi, 0);
    write_ctl(1'b1, 1'b0);
    chk("R9 write without clear keeps alarm", alarm_stat, 1);
    chk("R9 safe code held", freq_sel, safe_code);
    write_ctl(1'b1, 1'b1);
    chk("R9 clear drops alarm", alarm_stat, 0);
    chk("R7 normal code after clear", freq_sel, norm_code);
    expect_expiry(window(3), "R9 restart by clear");
    write_ctl(1'b1, 1'b1);

    // R5 zero timeout
    write_tmo(0);
    expect_expiry(window(0), "R5");
    write_ctl(1'b1, 1'b1);

    // R6 kick mid-window
    write_tmo(2);
    wait_cyc(5);
    do_kick();
    expect_expiry(window(2), "R6 kick");
    write_ctl(1'b1, 1'b1);

    // R6 restart on the final unit suppresses expiry
    write_tmo(2);
    wait_cyc(window(2) - 1);
    do_kick();
    chk("R6 kick on final unit blocks expiry", alarm_stat, 0);
    expect_expiry(window(2), "R6 after coincident kick");
    write_ctl(1'b1, 1'b1);

    // R6 timeout write restarts
    write_tmo(2);
    wait_cyc(7);
    write_tmo(2);
    expect_expiry(window(2), "R6 tmo write");
    write_ctl(1'b1, 1'b1);

    // Random mix
    for (int it = 0; it < 24; it++) begin
      norm_code = 5'($urandom);
      safe_code = 5'($urandom);
      n = $urandom % 6;
      t = window(n);
      if (($urandom % 5) == 0) begin
        write_ctl(1'b0, 1'b1);
        write_tmo(n);
        hi = 0;
        for (int i = 0; i < 3 * t; i++) begin
          if (alarm_stat || sys_rst_req) hi++;
          wait_cyc(1);
        end
        chk("R3 random disabled", hi, 0);
        write_ctl(1'b1, 1'b1);
      end else begin
        write_tmo(n);
        k = $urandom % t;
        wait_cyc(k);
        do_kick();
        expect_expiry(t, "R6 random kick");
        write_ctl(1'b1, 1'b1);
        chk("R9 random clear", alarm_stat, 0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule